// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the device side of a 1024-word by 16-bit serial EEPROM, written as synchronous logic. A host selects it with an active-low chip select and clocks command frames in on a serial data input, one bit per rising edge of the serial clock. The serial clock, chip select, data input and write-control input are sampled on a fast system clock, and the block finds serial-clock edges by comparing each sample with the one before. A frame opens with a fixed 4-bit start pattern, carries a 2-bit operation field, and ends with a 10-bit field that holds either an address, sent low bit first, or a sub-code. Four operations are decoded: word read, word write, write enable and write disable.

A read shifts the addressed word out on the falling serial-clock edges and moves on to the next address for as long as the host keeps clocking. A write clocks in 16 data bits and then starts a programming cycle with a fixed length. During that cycle the ready output is low and the block accepts no commands. A write replaces the whole word, so no separate erase command exists. Raising write-control during the cycle aborts it. A host that has no ready pin can read the same status on the data output. The programming time is a parameter counted in system-clock cycles.

Top module: `eep_cmd_engine`

## Requirements
- R1: After reset, `rdy` is 1, `do_en` is 0, writes are disabled, and every word of the array reads 0.
- R2: A frame is sampled on rising `sk` edges while `cs_n` is 0. The first bits are 1,0,1,0 and the next two are the operation: 1,0 = read, 0,1 = write, 0,0 = special. For read and write, the following 10 bits are the address, A0 first. For special, the first two of those 10 bits select enable (1,1) or disable (0,0), and the rest are don't-care. The header is always 16 bits.
- R3: In a read, the word is driven on `do_o` least significant bit first, one bit on each falling `sk` edge. The first bit appears on the falling edge that follows the 16th rising edge, and `do_en` is 1 while the bits are driven.
- R4: If clocking continues after the 16th bit of a read, the word at the next address follows with no new header. Address 1023 is followed by address 0.
- R5: A write takes 32 rising edges, with the data sent D0 first. `rdy` falls on the 32nd rising edge and stays low for exactly PROG_CYCLES system clocks. When it rises, the whole word has been replaced by the new data.
- R6: A write sent while writes are disabled leaves the word unchanged and never pulls `rdy` low. Write enable turns writes on, and write disable turns them off again.
- R7: If `wc` is 1 during a programming cycle, `rdy` returns to 1 on the next clock and the addressed word keeps its old value.
- R8: `wc` has no effect on read, write enable or write disable frames.
- R9: While `cs_n` is 1, `do_en` is 0. Raising `cs_n` cancels a read at any point, and while the block is ready it also returns the command logic to waiting for a start pattern.
- R10: A programming cycle runs to completion whatever `cs_n` does, and frames clocked in while `rdy` is 0 are ignored.
- R11: If `cs_n` falls while `sk` is 0 after a write has started, `do_en` becomes 1 and `do_o` follows `rdy` until `cs_n` rises again.
- R12: A frame whose first four bits are not 1,0,1,0 is ignored until `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial command, address and data input |
| wc | input | 1 | Write control; 1 aborts a programming cycle |
| do_o | output | 1 | Serial data or status output value |
| do_en | output | 1 | Output enable for `do_o`; 0 means high impedance |
| rdy | output | 1 | 1 when ready, 0 while a programming cycle runs |

## Verification
The assertions check these rules on every cycle:
- the output is never enabled while chip select is high;
- busy can only begin on a rising serial-clock edge taken with chip select low;
- a busy period never lasts longer than the programming time;
- write-control ends a busy period on the next clock;
- while busy, the status shown on the data output is low.

Some behaviour depends on data and on whole sequences, and only the bench's scenarios can show it:
- the serial order of address and data bits;
- reads that continue into the next address and wrap to address 0;
- the word contents left after an aborted write or an ignored write;
- the write-enable state;
- frames that are ignored because of a bad start pattern or because the block was busy.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_HOLD,
    ST_READ,
    ST_WDATA,
    ST_BUSY
  } eep_state_e;

  localparam logic [3:0] START_PAT  = 4'b1010;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] SUB_ENABLE = 2'b11;
  localparam logic [1:0] SUB_LOCK   = 2'b00;

endpackage

// File: rtl/eep_edge_det.sv
module eep_edge_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sig_in;
  end

  assign rise = sig_in & ~prev_q;
  assign fall = ~sig_in & prev_q;

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic done
);

  localparam int TMR_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = TMR_W'(PROG_CYCLES - 1);
    end else if (run_q) begin
      if (abort || (cnt_q == '0)) run_d = 1'b0;
      else                        cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign done = run_q && (cnt_q == '0);

endmodule

// File: rtl/eep_word_array.sv
module eep_word_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/eep_frame_ctrl.sv
module eep_frame_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sk_lvl,
  input  logic              sk_rise,
  input  logic              sk_fall,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              di,
  input  logic              wc,
  input  logic              tmr_done,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              commit,
  output logic              prog_start,
  output logic              prog_abort,
  output logic              rdy,
  output logic              do_o,
  output logic              do_en
);

  localparam int HDR_LEN = 4 + 2 + ADDR_W;
  localparam int MAX_LEN = (HDR_LEN > DATA_W) ? HDR_LEN : DATA_W;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int BIT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  eep_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HDR_LEN-1:0] hdr_q, hdr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] rsh_q, rsh_d;
  logic [BIT_W-1:0]  bcnt_q, bcnt_d;
  logic [DATA_W-1:0] wsh_q, wsh_d;
  logic              dbit_q, dbit_d;
  logic              ract_q, ract_d;
  logic              wen_q, wen_d;
  logic              arm_q, arm_d;
  logic              stat_q, stat_d;

  logic [HDR_LEN-1:0] hdr_nxt;
  logic [ADDR_W-1:0]  dec_addr;
  logic [1:0]         op_fld;
  logic [1:0]         sub_fld;

  // Header decode: first bit received lands in the MSB; A0 is the first address bit.
  always_comb begin
    hdr_nxt = {hdr_q[HDR_LEN-2:0], di};
    for (int i = 0; i < ADDR_W; i++) dec_addr[i] = hdr_nxt[ADDR_W-1-i];
    op_fld  = hdr_nxt[ADDR_W+1:ADDR_W];
    sub_fld = hdr_nxt[ADDR_W-1:ADDR_W-2];
  end

  assign rd_addr = (state_q == ST_HDR) ? dec_addr : addr_q + 1'b1;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    hdr_d      = hdr_q;
    addr_d     = addr_q;
    rsh_d      = rsh_q;
    bcnt_d     = bcnt_q;
    wsh_d      = wsh_q;
    dbit_d     = dbit_q;
    ract_d     = ract_q;
    wen_d      = wen_q;
    arm_d      = arm_q;
    stat_d     = stat_q;
    prog_start = 1'b0;

    if (cs_fall && !sk_lvl && arm_q) stat_d = 1'b1;
    if (cs_rise)                     stat_d = 1'b0;
    if (cs_n && (state_q != ST_BUSY)) arm_d = 1'b0;

    if (cs_n && (state_q != ST_BUSY)) begin
      state_d = ST_HDR;
      cnt_d   = '0;
      ract_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_HDR: begin
          if (sk_rise) begin
            hdr_d = hdr_nxt;
            cnt_d = cnt_q + 1'b1;
            if ((cnt_q == CNT_W'(3)) && (hdr_nxt[3:0] != START_PAT)) begin
              state_d = ST_HOLD;
            end else if (cnt_q == CNT_W'(HDR_LEN - 1)) begin
              cnt_d  = '0;
              addr_d = dec_addr;
              if (op_fld == OP_READ) begin
                state_d = ST_READ;
                rsh_d   = rd_data;
                bcnt_d  = '0;
                ract_d  = 1'b0;
              end else if ((op_fld == OP_WRITE) && wen_q) begin
                state_d = ST_WDATA;
              end else begin
                state_d = ST_HOLD;
                if (op_fld == OP_SPECIAL) begin
                  if (sub_fld == SUB_ENABLE)    wen_d = 1'b1;
                  else if (sub_fld == SUB_LOCK) wen_d = 1'b0;
                end
              end
            end
          end
        end
        ST_READ: begin
          if (sk_fall) begin
            dbit_d = rsh_q[0];
            ract_d = 1'b1;
            if (bcnt_q == BIT_W'(DATA_W - 1)) begin
              rsh_d  = rd_data;
              addr_d = addr_q + 1'b1;
              bcnt_d = '0;
            end else begin
              rsh_d  = {1'b0, rsh_q[DATA_W-1:1]};
              bcnt_d = bcnt_q + 1'b1;
            end
          end
        end
        ST_WDATA: begin
          if (sk_rise) begin
            wsh_d = {di, wsh_q[DATA_W-1:1]};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              state_d    = ST_BUSY;
              prog_start = 1'b1;
              arm_d      = 1'b1;
            end
          end
        end
        ST_BUSY: begin
          if (wc || tmr_done) state_d = ST_HOLD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HDR;
      cnt_q   <= '0;
      hdr_q   <= '0;
      addr_q  <= '0;
      rsh_q   <= '0;
      bcnt_q  <= '0;
      wsh_q   <= '0;
      dbit_q  <= 1'b0;
      ract_q  <= 1'b0;
      wen_q   <= 1'b0;
      arm_q   <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hdr_q   <= hdr_d;
      addr_q  <= addr_d;
      rsh_q   <= rsh_d;
      bcnt_q  <= bcnt_d;
      wsh_q   <= wsh_d;
      dbit_q  <= dbit_d;
      ract_q  <= ract_d;
      wen_q   <= wen_d;
      arm_q   <= arm_d;
      stat_q  <= stat_d;
    end
  end

  assign rdy        = (state_q != ST_BUSY);
  assign prog_abort = (state_q == ST_BUSY) && wc;
  assign commit     = (state_q == ST_BUSY) && tmr_done && !wc;
  assign wr_addr    = addr_q;
  assign wr_data    = wsh_q;
  assign do_o       = stat_q ? rdy : dbit_q;
  assign do_en      = !cs_n && (stat_q || ((state_q == ST_READ) && ract_q));

endmodule

// File: rtl/eep_cmd_engine.sv
module eep_cmd_engine #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sk,
  input  logic di,
  input  logic wc,
  output logic do_o,
  output logic do_en,
  output logic rdy
);

  logic              sk_rise, sk_fall;
  logic              cs_rise, cs_fall;
  logic              tmr_done, prog_start, prog_abort, commit;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  eep_edge_det #(.RST_VAL(1'b0)) u_sk_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(sk), .rise(sk_rise), .fall(sk_fall)
  );

  eep_edge_det #(.RST_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(cs_n), .rise(cs_rise), .fall(cs_fall)
  );

  eep_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sk_lvl(sk),
    .sk_rise(sk_rise), .sk_fall(sk_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .di(di), .wc(wc), .tmr_done(tmr_done), .rd_data(rd_data),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .prog_start(prog_start), .prog_abort(prog_abort),
    .rdy(rdy), .do_o(do_o), .do_en(do_en)
  );

  eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .abort(prog_abort), .done(tmr_done)
  );

  eep_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(commit), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

endmodule

// File: rtl/eep_cmd_engine_chk.sv
module eep_cmd_engine_chk #(
  parameter int PROG_CYCLES = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sk,
  input logic wc,
  input logic do_o,
  input logic do_en,
  input logic rdy
);

  logic [31:0] busy_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len_q <= '0;
    else if (!rdy) busy_len_q <= busy_len_q + 1'b1;
    else           busy_len_q <= '0;
  end

  // R9
  hiz_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !do_en);

  // R5
  busy_starts_on_sk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> ($past(sk) && !$past(sk, 2) && !$past(cs_n)));

  // R5
  busy_length_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len_q <= PROG_CYCLES);

  // R7
  wc_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && wc) |=> rdy);

  // R11
  status_busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_en && !rdy) |-> !do_o);

endmodule

bind eep_cmd_engine eep_cmd_engine_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sk(sk), .wc(wc),
  .do_o(do_o), .do_en(do_en), .rdy(rdy)
);

// File: tb/eep_cmd_engine_tb.sv
module eep_cmd_engine_tb;

  localparam int PROG = 40;

  logic clk, rst_n, cs_n, sk, di, wc;
  logic do_o, do_en, rdy;
  int   n_chk, n_err;

  eep_cmd_engine #(.ADDR_W(10), .DATA_W(16), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sk(sk), .di(di), .wc(wc),
    .do_o(do_o), .do_en(do_en), .rdy(rdy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic clkn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    sk = 1'b0; di = b; clkn(4);
    sk = 1'b1; clkn(4);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [9:0] a);
    sk_bit(1'b1); sk_bit(1'b0); sk_bit(1'b1); sk_bit(1'b0);
    sk_bit(op[1]); sk_bit(op[0]);
    for (int i = 0; i < 10; i++) sk_bit(a[i]);
  endtask

  task automatic end_frame();
    sk = 1'b0; clkn(2);
    cs_n = 1'b1; di = 1'b0; clkn(4);
  endtask

  task automatic special(input bit enable);
    cs_n = 1'b0; clkn(2);
    send_cmd(2'b00, enable ? 10'h003 : 10'h000);
    end_frame();
  endtask

  task automatic read_words(input logic [9:0] a, input int n,
                            output logic [15:0] w0, output logic [15:0] w1, output bit en_ok);
    cs_n = 1'b0; clkn(2);
    send_cmd(2'b10, a);
    en_ok = 1'b1; w0 = '0; w1 = '0;
    for (int k = 0; k < 16 * n; k++) begin
      sk = 1'b0; clkn(3);
      if (!do_en) en_ok = 1'b0;
      if (k < 16) w0[k] = do_o;
      else        w1[k-16] = do_o;
      clkn(1);
      sk = 1'b1; clkn(4);
    end
    end_frame();
  endtask

  task automatic write_word(input logic [9:0] a, input logic [15:0] d,
                            input int abort_at, input bit drop_cs, output int busy_n);
    cs_n = 1'b0; clkn(2);
    send_cmd(2'b01, a);
    for (int i = 0; i < 15; i++) sk_bit(d[i]);
    sk = 1'b0; di = d[15]; clkn(4);
    sk = 1'b1; clkn(1);
    busy_n = 0;
    if (drop_cs) cs_n = 1'b1;
    while (!rdy && busy_n < 5000) begin
      if (busy_n == abort_at) wc = 1'b1;
      busy_n++;
      clkn(1);
    end
    wc = 1'b0;
    end_frame();
  endtask

  logic [15:0] w0, w1;
  bit          en_ok;
  int          bn;

  task automatic t_reset();
    chk(rdy == 1'b1, "R1", "rdy after reset", rdy, 1);
    chk(do_en == 1'b0, "R1", "do_en after reset", do_en, 0);
    read_words(10'd5, 1, w0, w1, en_ok);
    chk(w0 == 16'h0000, "R1", "array cleared", w0, 0);
  endtask

  task automatic t_disabled_write();
    write_word(10'd5, 16'h1234, -1, 1'b0, bn);
    chk(bn == 0, "R6", "no busy while disabled", bn, 0);
    read_words(10'd5, 1, w0, w1, en_ok);
    chk(w0 == 16'h0000, "R6", "word unchanged while disabled", w0, 0);
  endtask

  task automatic t_enable_write_read();
    special(1'b1);
    write_word(10'd5, 16'hA5C3, -1, 1'b0, bn);
    chk(bn == PROG, "R5", "busy length", bn, PROG);
    read_words(10'd5, 1, w0, w1, en_ok);
    chk(w0 == 16'hA5C3, "R3", "read data LSB first", w0, 16'hA5C3);
    chk(en_ok, "R3", "do_en during read", en_ok, 1);
    write_word(10'd5, 16'h0F0F, -1, 1'b0, bn);
    read_words(10'd5, 1, w0, w1, en_ok);
    chk(w0 == 16'h0F0F, "R5", "whole word replaced", w0, 16'h0F0F);
  endtask

  task automatic t_addr_order();
    write_word(10'd1, 16'h00C1, -1, 1'b0, bn);
    write_word(10'd512, 16'h8200, -1, 1'b0, bn);
    read_words(10'd1, 1, w0, w1, en_ok);
    chk(w0 == 16'h00C1, "R2", "address A0 first (addr 1)", w0, 16'h00C1);
    read_words(10'd512, 1, w0, w1, en_ok);
    chk(w0 == 16'h8200, "R2", "address A0 first (addr 512)", w0, 16'h8200);
  endtask

  task automatic t_seq_read();
    write_word(10'd1023, 16'hBEEF, -1, 1'b0, bn);
    write_word(10'd0, 16'h1357, -1, 1'b0, bn);
    read_words(10'd1023, 2, w0, w1, en_ok);
    chk(w0 == 16'hBEEF, "R4", "first word of burst", w0, 16'hBEEF);
    chk(w1 == 16'h1357, "R4", "wrap to address 0", w1, 16'h1357);
    read_words(10'd0, 2, w0, w1, en_ok);
    chk(w1 == 16'h00C1, "R4", "continue to address 1", w1, 16'h00C1);
  endtask

  task automatic t_abort();
    write_word(10'd7, 16'h7777, -1, 1'b0, bn);
    write_word(10'd7, 16'h1111, 10, 1'b0, bn);
    chk(bn == 11, "R7", "abort ends busy next clock", bn, 11);
    read_words(10'd7, 1, w0, w1, en_ok);
    chk(w0 == 16'h7777, "R7", "aborted word unchanged", w0, 16'h7777);
  endtask

  task automatic t_wc_ignored();
    wc = 1'b1;
    special(1'b0);
    wc = 1'b0;
    write_word(10'd8, 16'h0808, -1, 1'b0, bn);
    chk(bn == 0, "R8", "disable works with wc high", bn, 0);
    wc = 1'b1;
    special(1'b1);
    wc = 1'b0;
    write_word(10'd8, 16'h0880, -1, 1'b0, bn);
    chk(bn == PROG, "R8", "enable works with wc high", bn, PROG);
    wc = 1'b1;
    read_words(10'd8, 1, w0, w1, en_ok);
    wc = 1'b0;
    chk(w0 == 16'h0880, "R8", "read with wc high", w0, 16'h0880);
  endtask

  task automatic t_cancel_read();
    cs_n = 1'b0; clkn(2);
    send_cmd(2'b10, 10'd5);
    for (int k = 0; k < 5; k++) begin
      sk = 1'b0; clkn(4); sk = 1'b1; clkn(4);
    end
    sk = 1'b0; clkn(3);
    chk(do_en == 1'b1, "R3", "driving mid read", do_en, 1);
    cs_n = 1'b1; clkn(2);
    chk(do_en == 1'b0, "R9", "cs high releases output", do_en, 0);
    clkn(4);
    read_words(10'd5, 1, w0, w1, en_ok);
    chk(w0 == 16'h0F0F, "R9", "new frame after cancel", w0, 16'h0F0F);
    write_word(10'd12, 16'hC0DE, -1, 1'b1, bn);
    chk(bn == PROG, "R10", "cs high does not stop programming", bn, PROG);
    read_words(10'd12, 1, w0, w1, en_ok);
    chk(w0 == 16'hC0DE, "R10", "word written with cs high", w0, 16'hC0DE);
  endtask

  task automatic t_status();
    logic [15:0] d;
    d = 16'h9A9A;
    cs_n = 1'b0; clkn(2);
    send_cmd(2'b01, 10'd9);
    for (int i = 0; i < 16; i++) sk_bit(d[i]);
    sk = 1'b0; clkn(1);
    cs_n = 1'b1; clkn(2);
    cs_n = 1'b0; clkn(2);
    chk(do_en == 1'b1, "R11", "status output enabled", do_en, 1);
    chk(do_o == 1'b0, "R11", "status shows busy", do_o, 0);
    send_cmd(2'b00, 10'h000);
    sk = 1'b0; clkn(2);
    chk(rdy == 1'b1, "R11", "programming finished", rdy, 1);
    chk(do_en == 1'b1 && do_o == 1'b1, "R11", "status shows ready", {do_en, do_o}, 2'b11);
    cs_n = 1'b1; clkn(2);
    chk(do_en == 1'b0, "R11", "status released on cs high", do_en, 0);
    clkn(4);
    write_word(10'd10, 16'h5A5A, -1, 1'b0, bn);
    chk(bn == PROG, "R10", "disable frame during busy ignored", bn, PROG);
    read_words(10'd9, 1, w0, w1, en_ok);
    chk(w0 == d, "R11", "word written during status poll", w0, d);
  endtask

  task automatic t_bad_start();
    bit seen;
    seen = 1'b0;
    cs_n = 1'b0; clkn(2);
    sk_bit(1'b0);
    send_cmd(2'b10, 10'd5);
    for (int k = 0; k < 16; k++) begin
      sk = 1'b0; clkn(3);
      if (do_en) seen = 1'b1;
      clkn(1);
      sk = 1'b1; clkn(4);
    end
    end_frame();
    chk(!seen, "R12", "bad start pattern ignored", seen, 0);
    read_words(10'd5, 1, w0, w1, en_ok);
    chk(w0 == 16'h0F0F && en_ok, "R12", "next frame accepted", w0, 16'h0F0F);
  endtask

  task automatic t_lock();
    special(1'b0);
    write_word(10'd5, 16'hFFFF, -1, 1'b0, bn);
    chk(bn == 0, "R6", "no busy after disable", bn, 0);
    read_words(10'd5, 1, w0, w1, en_ok);
    chk(w0 == 16'h0F0F, "R6", "word unchanged after disable", w0, 16'h0F0F);
  endtask

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; cs_n = 1'b1; sk = 1'b0; di = 1'b0; wc = 1'b0;
    clkn(5);
    rst_n = 1'b1;
    clkn(2);
    t_reset();
    t_disabled_write();
    t_enable_write_read();
    t_addr_order();
    t_seq_read();
    t_abort();
    t_wc_ignored();
    t_cancel_read();
    t_status();
    t_bad_start();
    t_lock();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule